// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block is the shared receive store of a sixteen-line asynchronous serial multiplexer. Each line's receiver offers one finished character with valid/ready handshaking. The offer carries the character and a parity-error flag. It also carries a framing flag, which the receiver raises when it detects a break. One offer per cycle is accepted, and the lowest-numbered requesting line wins. The accepted character goes into a single first-in first-out store together with the number of the line that sent it. Software empties the store through a read strobe. Each read returns a 16-bit word whose sign bit says whether a character was present, so a driver can keep reading until the word is non-negative.

The block compares the number of stored entries against a programmable alarm level and raises a pending flag when that level is reached. A receive interrupt goes out while that flag is set and the interrupt enable is on. A control write can also force the pending flag through a loopback test. This lets software confirm the interrupt path when no character is stored. A master-clear bit in the control write discards every stored entry.

Back-pressure rules: `line_rdy` is combinational from `line_vld` and grants at most one line per cycle. A line must hold its offer until it sees `line_rdy` high at a rising edge. A granted offer is always consumed. When the store is full and no read happens in the same cycle, the granted character is discarded, and the loss is reported on the next character that is stored.

Top module: `rx_silo`

## Requirements
- R1: After reset the pending flag and the interrupt are low. `rd_word` is updated on the cycle after a cycle with `rd_en` high. The word has bit 15 set when it holds a character. A read of an empty store returns 16'h0000.
- R2: In a returned word, bits 7:0 hold the character and bits 11:8 hold the line number (0 to 15). Bit 12 is the parity-error flag and bit 13 is the framing (break) flag, as offered by the line.
- R3: When several lines offer at once, `line_rdy` is one-hot on the lowest-numbered offering line. It is never high for a line that is not offering. The other lines are served in later cycles, in ascending order.
- R4: Entries are returned in acceptance order. The store holds DEPTH entries; the default is 64.
- R5: A character accepted while the store is full, with no read in the same cycle, is discarded. The next character that is stored has bit 14 (overrun) set. Entries stored after it have bit 14 clear.
- R6: A read and an accepted offer in the same cycle are both carried out: the head entry is returned, the new entry is stored, and the number of entries stays the same.
- R7: The pending flag rises in the cycle in which the entry count reaches or exceeds the alarm level. The level is set with `alarm_wr`/`alarm_wdata` and resets to 16.
- R8: The pending flag clears when the count falls below the alarm level. It also clears on a control write with bit 7 = 0. After that software clear, the flag stays low until the count has fallen below the level and then reaches it again.
- R9: `rx_irq` is high exactly when the pending flag is set and receive-interrupt-enable (control bit 6, written on every control write) is 1.
- R10: A control write with bits 9 (maintenance), 7 and 6 all 1 sets the pending flag, even with an empty store. The flag stays set until a control write with bit 7 = 0.
- R11: A control write with bit 11 set empties the store. It also clears the pending flag, the stored overrun, interrupt enable and maintenance mode. The alarm level is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_vld | input | 16 | Per-line character offer valid |
| line_char | input | 128 | Per-line character, line i at bits 8i+7:8i |
| line_pe | input | 16 | Per-line parity-error flag |
| line_fe | input | 16 | Per-line framing/break flag |
| line_rdy | output | 16 | Per-line grant, one-hot or zero |
| rd_en | input | 1 | Read strobe, pops one entry |
| rd_word | output | 16 | Tagged word from the last read |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data (bits 6, 7, 9, 11 used) |
| alarm_wr | input | 1 | Alarm level write strobe |
| alarm_wdata | input | 7 | New alarm level |
| rx_pend | output | 1 | Receive pending flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest state to reach from the ports is the overrun case. It needs a store filled to all 64 entries, one offer discarded while full, then one read to make room, and only then a new character that should carry the overrun flag. The bench fills the store from rotating lines with distinct characters, makes the discarded offer, frees one slot, and stores a marker character. It then drains all 64 entries. This confirms that order was kept, that the discarded character never appears, and that only the marker carries bit 14. The disarm-after-software-clear behaviour needs a similar walk: the count is pushed above the level, the flag is cleared, the count is dropped below the level and raised again.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int NLINES = 16;
  localparam int CHW    = 8;
  localparam int LNW    = $clog2(NLINES);

  // control write bit positions
  localparam int C_RIE   = 6;
  localparam int C_RFLAG = 7;
  localparam int C_MAINT = 9;
  localparam int C_MCLR  = 11;

  typedef struct packed {
    logic           ovr;
    logic           fe;
    logic           pe;
    logic [LNW-1:0] line;
    logic [CHW-1:0] ch;
  } silo_ent_t;
endpackage

// File: rtl/rx_line_arb.sv
module rx_line_arb #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end

  // R3
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R3
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  silo_ent_t     push_ent,
  input  logic          pop,
  output logic [15:0]   rd_word,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  localparam int EW = $bits(silo_ent_t);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          ovr_pend;
  logic          full, empty, do_pop, do_push, drop;
  silo_ent_t     wr_ent;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_pop  = pop && !empty && !clr;
  assign do_push = push && !clr && (!full || do_pop);
  assign drop    = push && !clr && full && !do_pop;

  always_comb begin
    wr_ent     = push_ent;
    wr_ent.ovr = push_ent.ovr | ovr_pend;
  end

  assign cnt_nxt = clr ? '0 : (cnt + CW'(do_push) - CW'(do_pop));

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wr_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      ovr_pend <= 1'b0;
      rd_word  <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (pop) rd_word <= (pop && !empty) ? {1'b1, mem[rp]} : 16'h0000;
      if (clr) begin
        wp       <= '0;
        rp       <= '0;
        ovr_pend <= 1'b0;
      end else begin
        if (do_push) wp <= bump(wp);
        if (do_pop)  rp <= bump(rp);
        if (drop)         ovr_pend <= 1'b1;
        else if (do_push) ovr_pend <= 1'b0;
      end
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  // R1
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n) (pop && empty) |=> (rd_word == 16'h0000));
  // R5
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) drop |=> $stable(cnt));
  // R6
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (do_push && do_pop) |=> $stable(cnt));
endmodule

// File: rtl/rx_silo_irq.sv
module rx_silo_irq
  import rx_silo_pkg::*;
#(
  parameter int CW        = 7,
  parameter int ALARM_RST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [15:0]   ctl_wdata,
  input  logic          alarm_wr,
  input  logic [CW-1:0] alarm_wdata,
  input  logic [CW-1:0] cnt_nxt,
  output logic          clr,
  output logic          rx_pend,
  output logic          rx_irq
);
  logic          rie, maint, lvl_pend, armed, tst_pend;
  logic [CW-1:0] alarm_q;
  logic          sw_clr, below, tst_set;
  logic          ctl_unused;

  assign ctl_unused = ^{ctl_wdata[15:12], ctl_wdata[10], ctl_wdata[8], ctl_wdata[5:0], maint};
  assign clr     = ctl_wr && ctl_wdata[C_MCLR];
  assign sw_clr  = ctl_wr && !ctl_wdata[C_RFLAG] && !clr;
  assign tst_set = ctl_wr && !clr && ctl_wdata[C_MAINT] && ctl_wdata[C_RFLAG] && ctl_wdata[C_RIE];
  assign below   = cnt_nxt < alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rie      <= 1'b0;
      maint    <= 1'b0;
      lvl_pend <= 1'b0;
      armed    <= 1'b1;
      tst_pend <= 1'b0;
      alarm_q  <= CW'(ALARM_RST);
    end else begin
      if (alarm_wr) alarm_q <= alarm_wdata;
      if (clr) begin
        rie      <= 1'b0;
        maint    <= 1'b0;
        lvl_pend <= 1'b0;
        armed    <= 1'b1;
        tst_pend <= 1'b0;
      end else begin
        if (ctl_wr) begin
          rie   <= ctl_wdata[C_RIE];
          maint <= ctl_wdata[C_MAINT];
        end
        if (tst_set)     tst_pend <= 1'b1;
        else if (sw_clr) tst_pend <= 1'b0;
        if (sw_clr) begin
          lvl_pend <= 1'b0;
          armed    <= 1'b0;
        end else if (below) begin
          lvl_pend <= 1'b0;
          armed    <= 1'b1;
        end else if (armed) begin
          lvl_pend <= 1'b1;
        end
      end
    end
  end

  assign rx_pend = lvl_pend | tst_pend;
  assign rx_irq  = rx_pend & rie;

  // R8
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) sw_clr |=> !rx_pend);
  // R11
  mclr_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (!rx_pend && !rx_irq));
  // R10
  loop_set_chk: assert property (@(posedge clk) disable iff (!rst_n) tst_set |=> rx_pend);
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int ALARM_RST = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLINES-1:0]     line_vld,
  input  logic [NLINES*CHW-1:0] line_char,
  input  logic [NLINES-1:0]     line_pe,
  input  logic [NLINES-1:0]     line_fe,
  output logic [NLINES-1:0]     line_rdy,
  input  logic                  rd_en,
  output logic [15:0]           rd_word,
  input  logic                  ctl_wr,
  input  logic [15:0]           ctl_wdata,
  input  logic                  alarm_wr,
  input  logic [CW-1:0]         alarm_wdata,
  output logic                  rx_pend,
  output logic                  rx_irq
);
  logic [NLINES-1:0] gnt;
  silo_ent_t         ent;
  logic              clr;
  logic [CW-1:0]     cnt, cnt_nxt;
  logic              cnt_unused;

  assign cnt_unused = ^cnt;

  rx_line_arb #(.N(NLINES)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(line_vld), .gnt(gnt)
  );

  assign line_rdy = gnt;

  always_comb begin
    ent = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (gnt[i]) begin
        ent.ch   = line_char[i*CHW +: CHW];
        ent.line = LNW'(i);
        ent.pe   = line_pe[i];
        ent.fe   = line_fe[i];
      end
    end
  end

  rx_silo_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(|gnt), .push_ent(ent),
    .pop(rd_en), .rd_word(rd_word), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  rx_silo_irq #(.CW(CW), .ALARM_RST(ALARM_RST)) u_irq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .alarm_wr(alarm_wr), .alarm_wdata(alarm_wdata), .cnt_nxt(cnt_nxt),
    .clr(clr), .rx_pend(rx_pend), .rx_irq(rx_irq)
  );
endmodule

// File: tb/rx_silo_test.sv
module rx_silo_test;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  line_vld = '0;
  logic [127:0] line_char = '0;
  logic [15:0]  line_pe = '0;
  logic [15:0]  line_fe = '0;
  logic [15:0]  line_rdy;
  logic         rd_en = 1'b0;
  logic [15:0]  rd_word;
  logic         ctl_wr = 1'b0;
  logic [15:0]  ctl_wdata = '0;
  logic         alarm_wr = 1'b0;
  logic [6:0]   alarm_wdata = '0;
  logic         rx_pend, rx_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  rx_silo uut (
    .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .line_char(line_char),
    .line_pe(line_pe), .line_fe(line_fe), .line_rdy(line_rdy), .rd_en(rd_en),
    .rd_word(rd_word), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .alarm_wr(alarm_wr), .alarm_wdata(alarm_wdata), .rx_pend(rx_pend), .rx_irq(rx_irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push1(input int ln, input logic [7:0] ch, input logic p, input logic f);
    line_char[ln*8 +: 8] = ch;
    line_pe[ln] = p;
    line_fe[ln] = f;
    line_vld[ln] = 1'b1;
    @(negedge clk);
    line_vld[ln] = 1'b0;
  endtask

  task automatic rd(output logic [15:0] w);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    w = rd_word;
  endtask

  task automatic ctl(input logic [15:0] w);
    ctl_wr = 1'b1;
    ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic set_alarm(input logic [6:0] a);
    alarm_wr = 1'b1;
    alarm_wdata = a;
    @(negedge clk);
    alarm_wr = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] w;
    check("R1 pend after reset", {15'd0, rx_pend}, 16'h0);
    check("R1 irq after reset", {15'd0, rx_irq}, 16'h0);
    rd(w);
    check("R1 empty read", w, 16'h0000);
  endtask

  task automatic t_fields;
    logic [15:0] w;
    push1(5, 8'hA5, 1'b1, 1'b0);
    rd(w);
    check("R2 parity word line 5", w, 16'h95A5);
    push1(15, 8'h3C, 1'b0, 1'b1);
    rd(w);
    check("R2 break word line 15", w, 16'hAF3C);
  endtask

  task automatic t_prio;
    logic [15:0] w;
    line_char[3*8 +: 8] = 8'h33;
    line_char[9*8 +: 8] = 8'h99;
    line_pe[3] = 0; line_fe[3] = 0; line_pe[9] = 0; line_fe[9] = 0;
    line_vld[3] = 1'b1;
    line_vld[9] = 1'b1;
    #1;
    check("R3 grant lowest line", line_rdy, 16'h0008);
    @(negedge clk);
    line_vld[3] = 1'b0;
    #1;
    check("R3 grant next line", line_rdy, 16'h0200);
    @(negedge clk);
    line_vld[9] = 1'b0;
    rd(w);
    check("R4 first out line 3", w, 16'h8333);
    rd(w);
    check("R4 second out line 9", w, 16'h8999);
  endtask

  task automatic t_full;
    logic [15:0] w;
    int bad;
    ctl(16'h0800);
    for (int i = 0; i < 64; i++) push1(i % 16, 8'(i), 1'b0, 1'b0);
    push1(0, 8'hEE, 1'b0, 1'b0);
    rd(w);
    check("R4 head after fill", w, 16'h8000);
    push1(1, 8'h77, 1'b0, 1'b0);
    bad = 0;
    for (int i = 1; i < 64; i++) begin
      rd(w);
      if (w !== (16'h8000 | 16'((i % 16) << 8) | 16'(i))) bad++;
    end
    check("R4 order of 63 entries", 16'(bad), 16'h0);
    rd(w);
    check("R5 overrun on next stored", w, 16'hC177);
    rd(w);
    check("R5 dropped char absent", w, 16'h0000);
    push1(2, 8'h12, 1'b0, 1'b0);
    rd(w);
    check("R5 overrun only once", w, 16'h8212);
  endtask

  task automatic t_simul;
    logic [15:0] w;
    ctl(16'h0800);
    push1(2, 8'h11, 1'b0, 1'b0);
    push1(2, 8'h22, 1'b0, 1'b0);
    line_char[4*8 +: 8] = 8'h44;
    line_pe[4] = 0; line_fe[4] = 0;
    line_vld[4] = 1'b1;
    rd_en = 1'b1;
    @(negedge clk);
    line_vld[4] = 1'b0;
    rd_en = 1'b0;
    check("R6 head during push", rd_word, 16'h8211);
    rd(w);
    check("R6 second entry", w, 16'h8222);
    rd(w);
    check("R6 pushed entry kept", w, 16'h8444);
    rd(w);
    check("R6 count unchanged then empty", w, 16'h0000);
  endtask

  task automatic t_alarm;
    logic [15:0] w;
    ctl(16'h0800);
    set_alarm(7'd4);
    for (int i = 0; i < 3; i++) push1(0, 8'(i), 1'b0, 1'b0);
    check("R7 below level no pend", {15'd0, rx_pend}, 16'h0);
    push1(0, 8'h03, 1'b0, 1'b0);
    check("R7 pend at level", {15'd0, rx_pend}, 16'h1);
    check("R9 no irq without enable", {15'd0, rx_irq}, 16'h0);
    ctl(16'h00C0);
    check("R9 irq with enable", {15'd0, rx_irq}, 16'h1);
    rd(w);
    check("R8 pend clears below level", {15'd0, rx_pend}, 16'h0);
    check("R9 irq follows pend", {15'd0, rx_irq}, 16'h0);
    push1(0, 8'h04, 1'b0, 1'b0);
    check("R8 rearmed pend", {15'd0, rx_pend}, 16'h1);
    ctl(16'h0040);
    check("R8 software clear", {15'd0, rx_pend}, 16'h0);
    push1(0, 8'h05, 1'b0, 1'b0);
    check("R8 disarmed above level", {15'd0, rx_pend}, 16'h0);
    rd(w);
    rd(w);
    push1(0, 8'h06, 1'b0, 1'b0);
    check("R8 fires after re-reaching level", {15'd0, rx_pend}, 16'h1);
  endtask

  task automatic t_maint;
    logic [15:0] w;
    ctl(16'h0800);
    check("R11 pend cleared by master clear", {15'd0, rx_pend}, 16'h0);
    ctl(16'h02C0);
    check("R10 loopback pend", {15'd0, rx_pend}, 16'h1);
    check("R10 loopback irq", {15'd0, rx_irq}, 16'h1);
    rd(w);
    check("R10 silo still empty", w, 16'h0000);
    check("R10 pend held", {15'd0, rx_pend}, 16'h1);
    ctl(16'h0240);
    check("R10 cleared by bit 7 low", {15'd0, rx_pend}, 16'h0);
  endtask

  task automatic t_mclr;
    logic [15:0] w;
    set_alarm(7'd2);
    ctl(16'h00C0);
    for (int i = 0; i < 3; i++) push1(7, 8'(i), 1'b0, 1'b0);
    check("R7 pend before clear", {15'd0, rx_irq}, 16'h1);
    ctl(16'h08C0);
    check("R11 pend after clear", {15'd0, rx_pend}, 16'h0);
    rd(w);
    check("R11 silo emptied", w, 16'h0000);
    push1(7, 8'h50, 1'b0, 1'b0);
    push1(7, 8'h51, 1'b0, 1'b0);
    check("R11 alarm kept pend", {15'd0, rx_pend}, 16'h1);
    check("R11 enable cleared", {15'd0, rx_irq}, 16'h0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_prio();
    t_full();
    t_simul();
    t_alarm();
    t_maint();
    t_mclr();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule